// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Sequencer

This block sits between a host and the pin interface of an asynchronous pseudo-SRAM. It reads or writes the device's 16-bit configuration register without help from the host. A one-cycle command selects one of three operations:

- a software read;
- a software write;
- a sleep-pin load.

For either software command the block issues a fixed run of four bus operations at the top address. For a pin load it lowers the sleep pin and issues a single write that carries the value on the address lines. The block also keeps a shadow copy of the register and decodes its fields: refresh extent, sleep choice and temperature range.

The host samples `busy`, then pulses `cmdValid` with an opcode and a value. `done` marks the end of the command. After a software read, `rdData` holds the value that was read. A software write that would select deep power-down is refused with `rejected`, and no bus traffic is issued for it. Timing of the strobes is set in clock cycles by parameters.

Top module: `psram_cfg_seq`

## Requirements
- R1: After reset the shadow holds 0070h, fullRefresh=1, sleepPar=1, tempCode=11 and tempLimit=85. The following pins are high: ceN, oeN, weN, zzN, and byteEnN=11. dqOe, busy and done are low.
- R2: Opcode 01 (software write) runs four operations: read, read, write, write. Each holds ceN low for its own period and is followed by at least one cycle with ceN high. The third operation drives 0000h on dqOut and the fourth drives the command value. byteEnN is 00 in every operation. At done, the shadow equals the value.
- R3: Every software operation drives addr to all ones (3FFFFFh for 22 address bits) and keeps zzN high.
- R4: Opcode 00 (software read) runs read, read, write (0000h), read. rdData and the shadow both take the data seen on the fourth operation.
- R5: A software write whose value has bit 4 at 0 issues no bus operation. It gives done together with rejected=1, and it leaves the shadow unchanged.
- R6: Opcode 10 (pin load) lowers zzN for ZZ_LEAD cycles before ceN falls, then issues one write. In that write, addr is the value zero-extended, byteEnN=11 and dqOe=0. zzN stays low until ceN has risen. The shadow takes the value, and bit 4 at 0 is accepted.
- R7: The fields decode as follows. fullRefresh=1 exactly when shadow bits 2:0 are 000. sleepPar equals bit 4. tempCode equals bits 6:5. tempLimit is 15, 45, 70 or 85 for codes 00, 01, 10 and 11.
- R8: A command is accepted only when busy is low and the opcode is 00, 01 or 10. Opcode 11, or any command while busy, causes no bus operation and no done.
- R9: done is a single-cycle pulse that comes after the last operation has released ceN. busy is high from acceptance until done. rejected is high only together with done.
- R10: oeN and weN are never low together. Either one is low only while ceN is low. Each operation holds ceN low for exactly ACT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 00 software read, 01 software write, 10 pin load |
| cmdData | input | 16 | Value to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Command finished (one cycle) |
| rejected | output | 1 | Write refused, valid with done |
| rdData | output | 16 | Value from the last software read |
| shadowCfg | output | 16 | Shadow copy of the register |
| fullRefresh | output | 1 | Whole array refreshed |
| sleepPar | output | 1 | Sleep pin selects partial refresh (1) or deep power-down (0) |
| tempCode | output | 2 | Temperature range code |
| tempLimit | output | 7 | Temperature range in degrees C |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| byteEnN | output | 2 | Upper/lower byte enables, active low |
| zzN | output | 1 | Sleep pin, active low |
| addr | output | ADDR_W | Address lines |
| dqOut | output | 16 | Data driven to the device |
| dqOe | output | 1 | Data bus drive enable |
| dqIn | input | 16 | Data returned by the device |

## Verification
The assertions check, on every cycle, the following pin rules:
- oeN and weN are never low together, and neither is low while ceN is high;
- each software operation uses the top address;
- a pin load keeps the data bus undriven with the byte enables off;
- done is a single-cycle pulse;
- a refusal leaves the shadow unchanged.

Only the bench scenarios can show the order of operations within a sequence, the data carried by each write, the value returned by a read, the sleep-pin lead time, the decoded fields and the commands that must be ignored. The bench shows these with a device model that records every operation.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

  typedef enum logic [1:0] {
    OP_SW_READ  = 2'd0,
    OP_SW_WRITE = 2'd1,
    OP_PIN_LOAD = 2'd2,
    OP_NONE     = 2'd3
  } cfgOp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZZLO,
    ST_ACT,
    ST_GAP,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;     // capture command value
    logic capRead;     // capture dqIn on the final read
    logic commitCmd;   // shadow <= command value
    logic commitRead;  // shadow <= captured read value
    logic driveVal;    // dqOut carries the command value
    logic pinAddr;     // addr carries the command value
  } seqStrobe_t;

  localparam int SLEEP_BIT = 4;
  localparam int PAR_LSB   = 0;
  localparam int PAR_W     = 3;
  localparam int TEMP_LSB  = 5;

endpackage

// File: rtl/psram_cfg_ctrl.sv
module psram_cfg_ctrl
  import psram_cfg_pkg::*;
#(
  parameter int ACT_CYC = 3,
  parameter int ZZ_LEAD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdSleepBit,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       rejected,
  output logic       ceN,
  output logic       oeN,
  output logic       weN,
  output logic [1:0] byteEnN,
  output logic       zzN,
  output logic       dqOe
);

  localparam int CNT_MAX = (ACT_CYC > ZZ_LEAD) ? ACT_CYC : ZZ_LEAD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ACT_LAST = CNT_W'(ACT_CYC - 1);
  localparam logic [CNT_W-1:0] ZZ_LAST  = CNT_W'(ZZ_LEAD - 1);

  seqState_t       state;
  cfgOp_t          kindReg;
  logic [1:0]      opIdx;
  logic [CNT_W-1:0] cnt;
  logic            rejReg;

  logic accept, rejectNow, isPin, curRead, lastOp, actEnd, inBus;

  assign accept    = (state == ST_IDLE) && cmdValid && (cmdOp != OP_NONE);
  assign rejectNow = accept && (cmdOp == OP_SW_WRITE) && !cmdSleepBit;
  assign isPin     = (kindReg == OP_PIN_LOAD);
  assign curRead   = !isPin && ((opIdx < 2'd2) ||
                                ((opIdx == 2'd3) && (kindReg == OP_SW_READ)));
  assign lastOp    = isPin || (opIdx == 2'd3);
  assign actEnd    = (state == ST_ACT) && (cnt == ACT_LAST);
  assign inBus     = (state == ST_ZZLO) || (state == ST_ACT) || (state == ST_GAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= OP_SW_READ;
      opIdx   <= '0;
      cnt     <= '0;
      rejReg  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          kindReg <= cfgOp_t'(cmdOp);
          opIdx   <= '0;
          cnt     <= '0;
          rejReg  <= rejectNow;
          if (rejectNow)                 state <= ST_DONE;
          else if (cmdOp == OP_PIN_LOAD) state <= ST_ZZLO;
          else                           state <= ST_ACT;
        end
        ST_ZZLO: begin
          if (cnt == ZZ_LAST) begin
            cnt   <= '0;
            state <= ST_ACT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACT: begin
          if (actEnd) begin
            cnt   <= '0;
            state <= ST_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (lastOp) begin
            state <= ST_DONE;
          end else begin
            opIdx <= opIdx + 1'b1;
            state <= ST_ACT;
          end
        end
        ST_DONE: begin
          rejReg <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadCmd    = accept;
    strobe.capRead    = actEnd && (kindReg == OP_SW_READ) && (opIdx == 2'd3);
    strobe.commitCmd  = (state == ST_GAP) && lastOp && (kindReg != OP_SW_READ);
    strobe.commitRead = (state == ST_GAP) && lastOp && (kindReg == OP_SW_READ);
    strobe.driveVal   = (kindReg == OP_SW_WRITE) && (opIdx == 2'd3);
    strobe.pinAddr    = isPin && inBus;
  end

  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign done     = (state == ST_DONE);
  assign rejected = (state == ST_DONE) && rejReg;
  assign ceN      = !(state == ST_ACT);
  assign oeN      = !((state == ST_ACT) && curRead);
  assign weN      = !((state == ST_ACT) && !curRead);
  assign byteEnN  = ((state == ST_ACT) && !isPin) ? 2'b00 : 2'b11;
  assign zzN      = !(isPin && inBus);
  assign dqOe     = (state == ST_ACT) && !curRead && !isPin;

endmodule

// File: rtl/psram_cfg_dp.sv
module psram_cfg_dp
  import psram_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter int          DATA_W    = 16,
  parameter logic [15:0] RESET_VAL = 16'h0070
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] shadowCfg,
  output logic              fullRefresh,
  output logic              sleepPar,
  output logic [1:0]        tempCode,
  output logic [6:0]        tempLimit
);

  logic [DATA_W-1:0] cmdVal;
  logic [ADDR_W-1:0] valAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdVal    <= '0;
      rdData    <= '0;
      shadowCfg <= DATA_W'(RESET_VAL);
    end else begin
      if (strobe.loadCmd)    cmdVal    <= cmdData;
      if (strobe.capRead)    rdData    <= dqIn;
      if (strobe.commitCmd)  shadowCfg <= cmdVal;
      if (strobe.commitRead) shadowCfg <= rdData;
    end
  end

  generate
    if (ADDR_W >= DATA_W) begin : g_widen
      assign valAddr = {{(ADDR_W - DATA_W){1'b0}}, cmdVal};
    end else begin : g_narrow
      assign valAddr = cmdVal[ADDR_W-1:0];
    end
  endgenerate

  assign addr  = strobe.pinAddr ? valAddr : '1;
  assign dqOut = strobe.driveVal ? cmdVal : '0;

  assign fullRefresh = (shadowCfg[PAR_LSB +: PAR_W] == '0);
  assign sleepPar    = shadowCfg[SLEEP_BIT];
  assign tempCode    = shadowCfg[TEMP_LSB +: 2];

  always_comb begin
    unique case (tempCode)
      2'd0:    tempLimit = 7'd15;
      2'd1:    tempLimit = 7'd45;
      2'd2:    tempLimit = 7'd70;
      default: tempLimit = 7'd85;
    endcase
  end

endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
  import psram_cfg_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int ACT_CYC = 3,
  parameter int ZZ_LEAD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [15:0]       cmdData,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic [15:0]       rdData,
  output logic [15:0]       shadowCfg,
  output logic              fullRefresh,
  output logic              sleepPar,
  output logic [1:0]        tempCode,
  output logic [6:0]        tempLimit,
  output logic              ceN,
  output logic              oeN,
  output logic              weN,
  output logic [1:0]        byteEnN,
  output logic              zzN,
  output logic [ADDR_W-1:0] addr,
  output logic [15:0]       dqOut,
  output logic              dqOe,
  input  logic [15:0]       dqIn
);

  seqStrobe_t strobe;

  psram_cfg_ctrl #(.ACT_CYC(ACT_CYC), .ZZ_LEAD(ZZ_LEAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSleepBit(cmdData[SLEEP_BIT]), .strobe(strobe), .busy(busy),
    .done(done), .rejected(rejected), .ceN(ceN), .oeN(oeN), .weN(weN),
    .byteEnN(byteEnN), .zzN(zzN), .dqOe(dqOe)
  );

  psram_cfg_dp #(.ADDR_W(ADDR_W), .DATA_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData),
    .dqIn(dqIn), .addr(addr), .dqOut(dqOut), .rdData(rdData),
    .shadowCfg(shadowCfg), .fullRefresh(fullRefresh), .sleepPar(sleepPar),
    .tempCode(tempCode), .tempLimit(tempLimit)
  );

endmodule

// File: rtl/psram_cfg_seq_chk.sv
module psram_cfg_seq_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              rejected,
  input logic [15:0]       shadowCfg,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [1:0]        byteEnN,
  input logic              zzN,
  input logic [ADDR_W-1:0] addr,
  input logic              dqOe
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN)); // R10

  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN || !weN) |-> !ceN); // R10

  AST_SW_TOP_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && zzN) |-> (addr == {ADDR_W{1'b1}})); // R3

  AST_PIN_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !zzN |-> (byteEnN == 2'b11 && !dqOe)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_REJECT_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> done); // R9

  AST_REJECT_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    (done && rejected) |-> $stable(shadowCfg)); // R5

endmodule

bind psram_cfg_seq psram_cfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .rejected(rejected),
  .shadowCfg(shadowCfg), .ceN(ceN), .oeN(oeN), .weN(weN),
  .byteEnN(byteEnN), .zzN(zzN), .addr(addr), .dqOe(dqOe)
);

// File: tb/sim_psram_cfg_seq.sv
module sim_psram_cfg_seq;

  localparam int ADDR_W  = 22;
  localparam int ACT_CYC = 3;
  localparam int ZZ_LEAD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [15:0] cmdData = 16'h0;
  logic busy, done, rejected, fullRefresh, sleepPar, ceN, oeN, weN, zzN, dqOe;
  logic [15:0] rdData, shadowCfg, dqOut, dqIn;
  logic [1:0] tempCode, byteEnN;
  logic [6:0] tempLimit;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  psram_cfg_seq #(.ADDR_W(ADDR_W), .ACT_CYC(ACT_CYC), .ZZ_LEAD(ZZ_LEAD)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .done(done), .rejected(rejected),
    .rdData(rdData), .shadowCfg(shadowCfg), .fullRefresh(fullRefresh),
    .sleepPar(sleepPar), .tempCode(tempCode), .tempLimit(tempLimit),
    .ceN(ceN), .oeN(oeN), .weN(weN), .byteEnN(byteEnN), .zzN(zzN),
    .addr(addr), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  // device model and operation log
  logic [15:0] devCr = 16'h0070;
  logic [15:0] topWord = 16'hA5C3;
  int          logLen = 0;
  int          doneCnt = 0;
  logic        logRd   [8];
  logic [ADDR_W-1:0] logAddr [8];
  logic [15:0] logData [8];
  logic [1:0]  logBe   [8];
  logic        logZz   [8];
  logic        logZzEnd[8];
  int          logDur  [8];
  int          logLead [8];
  logic        inOp = 1'b0;
  int          zzRun = 0;
  int          cur = 0;
  logic        badStrobe = 1'b0;

  assign dqIn = (!ceN && !oeN) ? ((logLen == 3) ? devCr : topWord) : 16'h0000;

  always @(negedge clk) begin
    if (done) doneCnt++;
    if (!zzN) zzRun++; else zzRun = 0;
    if ((!oeN || !weN) && ceN) badStrobe = 1'b1;
    if (!ceN) begin
      cur = (logLen < 8) ? logLen : 7;
      if (!inOp) begin
        inOp = 1'b1;
        logRd[cur]   = !oeN;
        logAddr[cur] = addr;
        logBe[cur]   = byteEnN;
        logZz[cur]   = zzN;
        logDur[cur]  = 0;
        logLead[cur] = zzRun;
        logData[cur] = 16'h0;
      end
      logDur[cur]++;
      if (!weN && dqOe) logData[cur] = dqOut;
    end else if (inOp) begin
      cur = (logLen < 8) ? logLen : 7;
      inOp = 1'b0;
      logZzEnd[cur] = zzN;
      if (!logRd[cur]) begin
        if (!logZz[cur]) devCr = logAddr[cur][15:0];
        else if (logLen == 3) devCr = logData[cur];
      end
      logLen++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLimit(input logic [15:0] v);
    case (v[6:5])
      2'd0: return 15;
      2'd1: return 45;
      2'd2: return 70;
      default: return 85;
    endcase
  endfunction

  task automatic checkFields(input logic [15:0] v);
    chk(shadowCfg == v, "R7 shadow", shadowCfg, v);
    chk(fullRefresh == (v[2:0] == 3'b000), "R7 fullRefresh", fullRefresh, v[2:0] == 3'b000);
    chk(sleepPar == v[4], "R7 sleepPar", sleepPar, v[4]);
    chk(tempCode == v[6:5], "R7 tempCode", tempCode, v[6:5]);
    chk(int'(tempLimit) == expLimit(v), "R7 tempLimit", tempLimit, expLimit(v));
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [15:0] val, input bit poke);
    logic [15:0] prevShadow, prevCr, expShadow;
    bit isRej;
    int wait_n;
    prevShadow = shadowCfg;
    prevCr = devCr;
    isRej = (op == 2'd1) && !val[4];
    logLen = 0;
    chk(!busy, "R8 idle before command", busy, 0);
    cmdValid = 1'b1; cmdOp = op; cmdData = val;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy == !isRej, "R9 busy after accept", busy, !isRej);
    wait_n = 0;
    while (!done && wait_n < 200) begin
      if (poke && wait_n == 2) begin
        cmdValid = 1'b1; cmdOp = 2'd2; cmdData = 16'h0003;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
      wait_n++;
    end
    cmdValid = 1'b0;
    chk(done, "R9 done reached", done, 1);
    chk(rejected == isRej, "R5 rejected flag", rejected, isRej);
    if (isRej) begin
      chk(logLen == 0, "R5 no bus operation", logLen, 0);
      expShadow = prevShadow;
    end else if (op == 2'd2) begin
      chk(logLen == 1, "R6 one operation", logLen, 1);
      chk(!logRd[0] && !logZz[0] && !logZzEnd[0], "R6 write with zz low", {logRd[0], logZz[0], logZzEnd[0]}, 0);
      chk(logAddr[0] == ADDR_W'(val), "R6 value on address", logAddr[0], val);
      chk(logBe[0] == 2'b11, "R6 byte enables off", logBe[0], 2'b11);
      chk(logLead[0] == ZZ_LEAD + 1, "R6 zz lead", logLead[0], ZZ_LEAD + 1);
      chk(logDur[0] == ACT_CYC, "R10 ce low duration", logDur[0], ACT_CYC);
      expShadow = val;
    end else begin
      chk(logLen == 4, "R2 four operations", logLen, 4);
      for (int i = 0; i < 4; i++) begin
        bit expRd;
        expRd = (i < 2) || (i == 3 && op == 2'd0);
        chk(logRd[i] == expRd, "R2 R4 operation kind", logRd[i], expRd);
        chk(logAddr[i] == {ADDR_W{1'b1}} && logZz[i], "R3 top address zz high", logAddr[i], {ADDR_W{1'b1}});
        chk(logBe[i] == 2'b00, "R2 byte enables on", logBe[i], 0);
        chk(logDur[i] == ACT_CYC, "R10 ce low duration", logDur[i], ACT_CYC);
      end
      chk(logData[2] == 16'h0000, "R2 third write zero", logData[2], 0);
      if (op == 2'd1) begin
        chk(logData[3] == val, "R2 fourth write value", logData[3], val);
        expShadow = val;
      end else begin
        chk(rdData == prevCr, "R4 read data", rdData, prevCr);
        expShadow = prevCr;
      end
    end
    checkFields(expShadow);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
    if (poke) begin
      repeat (12) @(negedge clk);
      chk(logLen == 4 && !busy, "R8 command while busy ignored", logLen, 4);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int dummy;
    dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(shadowCfg == 16'h0070, "R1 shadow reset", shadowCfg, 16'h0070);
    chk(fullRefresh && sleepPar && tempCode == 2'b11 && tempLimit == 7'd85,
        "R1 decoded reset", {fullRefresh, sleepPar, tempCode, tempLimit}, {1'b1, 1'b1, 2'b11, 7'd85});
    chk(ceN && oeN && weN && zzN && byteEnN == 2'b11 && !dqOe && !busy && !done,
        "R1 bus idle", {ceN, oeN, weN, zzN, byteEnN, dqOe, busy, done}, 9'b111111000);

    // directed corners
    runCmd(2'd0, 16'h0, 1'b0);             // R4 read of default
    runCmd(2'd1, 16'h0023, 1'b0);          // R5 reject: bit 4 clear
    runCmd(2'd2, 16'h0045, 1'b0);          // R6 pin load with deep power-down choice
    runCmd(2'd1, 16'h0010, 1'b0);          // R2 write, temp 15
    runCmd(2'd0, 16'h0, 1'b0);             // R4 read back
    runCmd(2'd1, 16'h0033, 1'b1);          // R8 command while busy
    // R8 unused opcode ignored
    begin
      logic [15:0] keep;
      int dc;
      keep = shadowCfg;
      dc = doneCnt;
      logLen = 0;
      cmdValid = 1'b1; cmdOp = 2'd3; cmdData = 16'h0011;
      @(negedge clk);
      cmdValid = 1'b0;
      repeat (10) @(negedge clk);
      chk(logLen == 0 && doneCnt == dc && !busy, "R8 opcode 11 ignored", logLen, 0);
      chk(shadowCfg == keep, "R8 shadow untouched", shadowCfg, keep);
    end

    // constrained random
    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      logic [15:0] v;
      op = 2'($urandom_range(0, 2));
      v = 16'($urandom());
      if ($urandom_range(0, 3) != 0 && op == 2'd1) v[4] = 1'b1;
      runCmd(op, v, 1'b0);
    end

    chk(!badStrobe, "R10 strobe without ce", badStrobe, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule